// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Tracker

This block watches an I2C bus from the slave side and decides whether the bus is running with standard/fast timing or with high-speed timing. It takes SCL and SDA, already synchronised to the system clock, along with one-cycle strobes from an existing START/STOP detector. It presents a mode flag and the length, in system-clock cycles, that the slave's glitch filter on SCL/SDA should use.

High-speed operation begins with a special first byte, the master code. Its upper five bits are `00001` and its lower three bits can take any value. The master sends it in standard/fast mode directly after a START. No device acknowledges it, so SDA stays high in the ninth clock. Once that ninth clock pulse ends, the bus is in high-speed mode. Any number of repeated STARTs keep it there. A STOP returns the bus to standard/fast mode. Any first byte other than a master code is an ordinary transfer and does not change the mode. Address decoding and acknowledge generation belong to other blocks.

States: `ST_IDLE` (standard/fast, no transfer being tracked), `ST_ADDR` (collecting the first byte after a START), `ST_MC_ACK` (master code seen, waiting for the ninth SCL rise), `ST_MC_HOLD` (ninth pulse high, waiting for SCL to fall), `ST_HS` (high-speed active), `ST_PASS` (ordinary transfer, no further bytes examined).

Transitions:
- A STOP strobe in any state goes to `ST_IDLE`.
- Otherwise, a START strobe keeps `ST_HS` in `ST_HS`, and from any other state goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_MC_ACK` on the eighth SCL rise if the byte is a master code, and to `ST_PASS` otherwise.
- `ST_MC_ACK` goes to `ST_MC_HOLD` on the next SCL rise.
- `ST_MC_HOLD` goes to `ST_HS` on the next SCL fall.

Top module: `hs_mode_tracker`

## Requirements
- R1: After reset, hs_mode is 0 and filt_len holds the standard/fast filter length.
- R2: A first byte after a START is sampled MSB first on SCL rising edges. If it is received in standard/fast mode and its bits 7..3 are 00001, hs_mode becomes 1 right after the SCL falling edge that ends the ninth clock pulse.
- R3: Bits 2..0 of the master code are ignored: all eight values 0x08 to 0x0F enter high-speed mode.
- R4: hs_mode stays 0 while the ninth clock of the master code is high. The SDA level in that acknowledge slot (left high) does not affect the decision.
- R5: A first byte whose bits 7..3 differ from 00001 (for example 0x90, 0x18, 0x00, 0x48) leaves hs_mode at 0 until the next START. Later bytes of that transfer are not examined, even if they equal a master code.
- R6: A START strobe while hs_mode is 1 (a repeated START) keeps hs_mode at 1, and the bytes that follow do not change it.
- R7: A STOP strobe sets hs_mode to 0 on the next cycle from any state. This includes a master code that has been received but not yet completed, which is then abandoned.
- R8: A START strobe in standard/fast mode before the master-code sequence completes discards the partial byte. The next byte is evaluated afresh as a first byte.
- R9: filt_len equals ceil(FS_SPIKE_NS / CLK_PERIOD_NS) while hs_mode is 0 and ceil(HS_SPIKE_NS / CLK_PERIOD_NS) while hs_mode is 1. With the defaults these are 3 and 1.
- R10: When START and STOP strobes arrive in the same cycle, the STOP takes effect and hs_mode goes to 0.
- R11: Once set, hs_mode falls only as a result of a STOP strobe (or reset). SCL/SDA traffic alone never clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Synchronised serial clock line |
| sda | input | 1 | Synchronised serial data line |
| start_det | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_det | input | 1 | One-cycle strobe: STOP seen |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| filt_len | output | FILT_W | Glitch-filter length in system-clock cycles for the current mode |

## Verification
The bench samples hs_mode while the ninth clock of a master code is still high and again after it falls. A design that switches on the rising edge or on the eighth bit shows 1 too early. It sends all eight master-code values, and a comparator that includes the low bits would reject seven of them. It sends a master-code value as the second byte of an ordinary transfer, aborts a master code with a repeated START or a STOP, and pulses START and STOP together. A design that inspects every byte, keeps stale bits or gives START priority would then be left in the wrong mode. Repeated STARTs in high-speed mode catch a design that drops back to standard/fast on any START.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

    // Upper bits of the high-speed master code, MSB first on the wire
    localparam int          MC_TOP_W   = 5;
    localparam logic [4:0]  MC_PREFIX  = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_MC_ACK  = 3'd2,
        ST_MC_HOLD = 3'd3,
        ST_HS      = 3'd4,
        ST_PASS    = 3'd5
    } hsm_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/hsm_scl_edge.sv
module hsm_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;

    // Idle bus has SCL high, so the history starts high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl;
        end
    end

    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
    end

endmodule

// File: rtl/hsm_byte_rx.sv
module hsm_byte_rx
    import hsm_pkg::*;
#(
    parameter int BITS  = 8,
    localparam int CNT_W = $clog2(BITS + 1),
    localparam int SH_W  = BITS - 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic sda,
    output logic byte_last,
    output logic is_master_code
);

    logic [SH_W-1:0]  shreg;
    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (clr) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (smp) begin
            shreg <= {shreg[SH_W-2:0], sda};
            if (bit_cnt < CNT_W'(BITS)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // On the last rise of a byte the upper bits already sit in the shifter,
    // so the low bits of the byte never take part in the decision.
    always_comb begin
        byte_last      = smp && (bit_cnt == CNT_W'(BITS - 1));
        is_master_code = (shreg[SH_W-1 -: MC_TOP_W] == MC_PREFIX);
    end

endmodule

// File: rtl/hsm_mode_fsm.sv
module hsm_mode_fsm
    import hsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic byte_last,
    input  logic is_master_code,
    output logic hs_active
);

    hsm_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic: STOP outranks START, START outranks bus edges
    always_comb begin
        state_nxt = state;
        if (stop_det) begin
            state_nxt = ST_IDLE;
        end else if (start_det) begin
            state_nxt = (state == ST_HS) ? ST_HS : ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_ADDR: begin
                    if (byte_last) begin
                        state_nxt = is_master_code ? ST_MC_ACK : ST_PASS;
                    end
                end
                ST_MC_ACK: begin
                    if (scl_rise) state_nxt = ST_MC_HOLD;
                end
                ST_MC_HOLD: begin
                    if (scl_fall) state_nxt = ST_HS;
                end
                ST_HS:   state_nxt = ST_HS;
                ST_PASS: state_nxt = ST_PASS;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hs_active = (state == ST_HS);
    end

endmodule

// File: rtl/hsm_filt_sel.sv
module hsm_filt_sel #(
    parameter int W      = 4,
    parameter int FS_CYC = 3,
    parameter int HS_CYC = 1
) (
    input  logic         hs,
    output logic [W-1:0] len
);

    localparam logic [W-1:0] FS_LEN = W'(FS_CYC);
    localparam logic [W-1:0] HS_LEN = W'(HS_CYC);

    always_comb begin
        len = hs ? HS_LEN : FS_LEN;
    end

endmodule

// File: rtl/hs_mode_tracker.sv
module hs_mode_tracker
    import hsm_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int FS_SPIKE_NS   = 50,
    parameter int HS_SPIKE_NS   = 10,
    parameter int FILT_W        = 4,
    parameter int BYTE_BITS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              hs_mode,
    output logic [FILT_W-1:0] filt_len
);

    localparam int FS_CYC = ceil_div(FS_SPIKE_NS, CLK_PERIOD_NS);
    localparam int HS_CYC = ceil_div(HS_SPIKE_NS, CLK_PERIOD_NS);

    logic scl_rise, scl_fall;
    logic byte_last, is_mc;

    hsm_scl_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    hsm_byte_rx #(.BITS(BYTE_BITS)) u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (start_det),
        .smp            (scl_rise),
        .sda            (sda),
        .byte_last      (byte_last),
        .is_master_code (is_mc)
    );

    hsm_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_det      (start_det),
        .stop_det       (stop_det),
        .scl_rise       (scl_rise),
        .scl_fall       (scl_fall),
        .byte_last      (byte_last),
        .is_master_code (is_mc),
        .hs_active      (hs_mode)
    );

    hsm_filt_sel #(.W(FILT_W), .FS_CYC(FS_CYC), .HS_CYC(HS_CYC)) u_filt (
        .hs  (hs_mode),
        .len (filt_len)
    );

endmodule

// File: rtl/hsm_checker.sv
module hsm_checker #(
    parameter int W      = 4,
    parameter int FS_CYC = 3,
    parameter int HS_CYC = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl,
    input logic         start_det,
    input logic         stop_det,
    input logic         hs_mode,
    input logic [W-1:0] filt_len
);

    // R2: entry happens just after SCL was seen going low
    p_entry_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> ($past(scl) == 1'b0) && ($past(scl, 2) == 1'b1));

    // R7: a STOP never coincides with entry and always clears the flag
    p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    p_no_entry_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> !$past(stop_det));

    // R6: repeated START holds high-speed mode
    p_rs_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode && start_det && !stop_det) |=> hs_mode);

    // R10: STOP wins over a simultaneous START
    p_stop_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && stop_det) |=> !hs_mode);

    // R11: only a STOP takes the flag down
    p_exit_by_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode) |-> $past(stop_det));

    // R9: filter length follows the mode
    p_filt_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mode |-> (filt_len == W'(HS_CYC)));

    p_filt_fs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_mode |-> (filt_len == W'(FS_CYC)));

endmodule

bind hs_mode_tracker hsm_checker #(
    .W      (FILT_W),
    .FS_CYC (FS_CYC),
    .HS_CYC (HS_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .hs_mode   (hs_mode),
    .filt_len  (filt_len)
);

// File: tb/hs_mode_tracker_test.sv
`timescale 1ns/1ps
module hs_mode_tracker_test;

    localparam int CLK_NS = 20;
    localparam int FS_NS  = 50;
    localparam int HS_NS  = 10;
    localparam int FW     = 4;
    localparam int HALF   = 4;
    localparam int EXP_FS = (FS_NS + CLK_NS - 1) / CLK_NS;
    localparam int EXP_HS = (HS_NS + CLK_NS - 1) / CLK_NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda = 1'b1;
    logic          start_det = 1'b0;
    logic          stop_det = 1'b0;
    logic          hs_mode;
    logic [FW-1:0] filt_len;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    bit    exp_hs_q[$];
    int    exp_filt_q[$];
    string tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    hs_mode_tracker #(
        .CLK_PERIOD_NS (CLK_NS),
        .FS_SPIKE_NS   (FS_NS),
        .HS_SPIKE_NS   (HS_NS),
        .FILT_W        (FW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl),
        .sda       (sda),
        .start_det (start_det),
        .stop_det  (stop_det),
        .hs_mode   (hs_mode),
        .filt_len  (filt_len)
    );

    // Monitor: compares queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (exp_hs_q.size() > 0) begin
                bit    e_hs;
                int    e_fl;
                string t;
                e_hs = exp_hs_q.pop_front();
                e_fl = exp_filt_q.pop_front();
                t    = tag_q.pop_front();
                n_cmp++;
                if (hs_mode !== e_hs || int'(filt_len) != e_fl) begin
                    n_fail++;
                    $display("FAIL %s: hs_mode=%0b filt_len=%0d expected hs_mode=%0b filt_len=%0d",
                             t, hs_mode, filt_len, e_hs, e_fl);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    task automatic half_bit();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic expect_mode(input bit hs, input string tag);
        exp_hs_q.push_back(hs);
        exp_filt_q.push_back(hs ? EXP_HS : EXP_FS);
        tag_q.push_back(tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic bus_start();
        if (scl == 1'b0) begin
            sda = 1'b1; half_bit();
            scl = 1'b1; half_bit();
        end
        sda = 1'b0;
        pulse_start();
        half_bit();
        scl = 1'b0; half_bit();
    endtask

    task automatic bus_stop();
        sda = 1'b0; half_bit();
        scl = 1'b1; half_bit();
        sda = 1'b1;
        stop_det = 1'b1;
        @(negedge clk);
        stop_det = 1'b0;
        half_bit();
    endtask

    task automatic send_bit(input bit b);
        sda = b;    half_bit();
        scl = 1'b1; half_bit();
        scl = 1'b0; half_bit();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
    endtask

    // byte plus acknowledge slot; ack_lvl is the SDA level in the ninth clock
    task automatic send_byte(input logic [7:0] v, input bit ack_lvl);
        send_bits(v, 8);
        send_bit(ack_lvl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_mode(1'b0, "R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_mode(1'b0, "R1 after reset release");

        // R2/R4: master code with a check inside the ninth clock
        bus_start();
        send_bits(8'h08, 8);
        sda = 1'b1; half_bit();
        scl = 1'b1; half_bit();
        expect_mode(1'b0, "R4 ninth clock high");
        scl = 1'b0; half_bit();
        expect_mode(1'b1, "R2 after ninth clock falls");
        expect_mode(1'b1, "R9 high-speed filter length");

        // R6/R11: repeated STARTs and traffic in high-speed mode
        bus_start();
        expect_mode(1'b1, "R6 repeated START");
        send_byte(8'h90, 1'b0);
        send_byte(8'h3C, 1'b0);
        expect_mode(1'b1, "R11 traffic does not clear");
        bus_start();
        send_byte(8'h09, 1'b1);
        bus_start();
        expect_mode(1'b1, "R6 third repeated START");

        // R7: STOP clears
        bus_stop();
        expect_mode(1'b0, "R7 STOP returns to standard/fast");
        expect_mode(1'b0, "R9 standard/fast filter length");

        // R3: every low-bit value of the master code
        for (int k = 0; k < 8; k++) begin
            bus_start();
            send_byte(8'h08 | 8'(k), 1'b1);
            expect_mode(1'b1, $sformatf("R3 master code low bits %0d", k));
            bus_stop();
            expect_mode(1'b0, "R7 STOP after master code");
        end

        // R5: ordinary first bytes, then a master-code value as a later byte
        begin
            logic [7:0] plain [4] = '{8'h90, 8'h18, 8'h00, 8'h48};
            for (int k = 0; k < 4; k++) begin
                bus_start();
                send_byte(plain[k], 1'b0);
                expect_mode(1'b0, $sformatf("R5 first byte 0x%02h", plain[k]));
                send_byte(8'h08, 1'b0);
                expect_mode(1'b0, "R5 later byte not examined");
                bus_stop();
            end
        end

        // R8: partial master code aborted by a repeated START
        bus_start();
        send_bits(8'h08, 5);
        bus_start();
        send_byte(8'h90, 1'b0);
        expect_mode(1'b0, "R8 aborted code then ordinary byte");
        bus_start();
        send_bits(8'h08, 3);
        bus_start();
        send_byte(8'h0D, 1'b1);
        expect_mode(1'b1, "R8 fresh byte after restart");
        bus_stop();
        expect_mode(1'b0, "R7 STOP");

        // R8: full master code byte aborted before the ninth clock
        bus_start();
        send_bits(8'h0B, 8);
        bus_start();
        send_byte(8'h48, 1'b0);
        expect_mode(1'b0, "R8 abort before ninth clock");
        bus_stop();

        // R7: STOP in the middle of a master code
        bus_start();
        send_bits(8'h0A, 8);
        bus_stop();
        expect_mode(1'b0, "R7 STOP mid master code");
        scl = 1'b1; half_bit();
        scl = 1'b0; half_bit();
        scl = 1'b1; half_bit();
        expect_mode(1'b0, "R7 abandoned code stays inactive");

        // R10: START and STOP strobes together while in high-speed mode
        bus_start();
        send_byte(8'h0F, 1'b1);
        expect_mode(1'b1, "R2 entry before collision");
        start_det = 1'b1;
        stop_det  = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        stop_det  = 1'b0;
        half_bit();
        expect_mode(1'b0, "R10 STOP wins");
        bus_stop();

        repeat (5) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule